// File: doc/BRIEF.md
# Acquisition Conversion Trigger Gate

This block sits in front of the converter in a data acquisition sequencer and decides which conversion requests reach it. A sequence is armed by a high-to-low edge on an active-low external trigger. That edge also switches on the enables for the sample counter and the sample-interval counter. The sequence stays armed until a sequence-done input or a software clear arrives.

Conversion requests come from one of two mutually exclusive sources: an active-low external convert pin, or the internal sample-interval timer pulse. A select bit chooses one source and holds the drive of the other off. While the sequence is armed, a request from the selected source is turned into a single-cycle convert pulse. A request is blocked when the external active-low gate is asserted or the software gate bit is set. Pulses on the external pin are qualified first. A pulse that is too narrow, or that falls too soon after the previous pulse, is not forwarded and sets a sticky violation flag. A separate strobe output gives a low pulse of fixed minimum width on request.

All asynchronous active-low inputs pass through a two-flop synchroniser. All timing is counted in system clock cycles.

Top module: `acq_conv_gate`

## Requirements
- R1: A high-to-low edge on `ext_trig_n` makes `seq_active`, `sample_cnt_en` and `intv_cnt_en` go high, and they stay high.
- R2: A one on `seq_done` or on `sw_clear` drives `seq_active` and both counter enables low on the next cycle. This clear takes priority over a trigger edge in the same cycle.
- R3: With the external source selected (`src_sel`=0), a low pulse on `ext_conv_n` that lasts at least MIN_WIDTH_CYC cycles and follows a high time of at least HOLDOFF_CYC cycles produces exactly one `conv_pulse`. A pulse of exactly MIN_WIDTH_CYC cycles is accepted.
- R4: A low pulse on `ext_conv_n` shorter than MIN_WIDTH_CYC cycles produces no `conv_pulse` and sets `width_viol`. A low time longer than the minimum has no upper limit.
- R5: A fall of `ext_conv_n` after fewer than HOLDOFF_CYC high cycles sets `holdoff_viol` and is not forwarded. A fall after exactly HOLDOFF_CYC high cycles is accepted.
- R6: No `conv_pulse` is produced from either source while `seq_active` is low.
- R7: No `conv_pulse` is produced while `ext_gate_n` is low or `sw_gate` is high.
- R8: `src_sel`=0 selects the external pin and `src_sel`=1 selects the internal timer. Exactly one of `ext_drv_en` and `int_drv_en` is high at all times. The unselected source produces neither convert pulses nor violation flags.
- R9: `conv_mon` equals `sint_pulse` while `src_sel`=1 and is 0 while `src_sel`=0.
- R10: A one on `sw_strobe` while `strobe_n` is high drives `strobe_n` low for exactly STROBE_CYC cycles. A request made while the strobe is low has no effect.
- R11: The violation flags are sticky. Writing one to `viol_clr` bit 0 clears `width_viol`, and writing one to bit 1 clears `holdoff_viol`. A new violation in the same cycle as its clear wins.
- R12: Each request gives a `conv_pulse` exactly one cycle wide. An internal request is taken on the rising edge of `sint_pulse`, so holding `sint_pulse` high for several cycles gives a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_conv_n | input | 1 | External convert request, active low, asynchronous |
| ext_trig_n | input | 1 | External sequence trigger, active low, asynchronous |
| ext_gate_n | input | 1 | External gate, active low, asynchronous; low blocks conversions |
| sint_pulse | input | 1 | Sample-interval timer output, synchronous |
| sw_gate | input | 1 | Software gate; high blocks conversions |
| src_sel | input | 1 | Convert source select: 0 external pin, 1 internal timer |
| seq_done | input | 1 | Sequence complete from sample-count logic |
| sw_clear | input | 1 | Software sequence clear |
| sw_strobe | input | 1 | Request a strobe pulse |
| viol_clr | input | 2 | Write-one-to-clear: bit 0 width flag, bit 1 holdoff flag |
| conv_pulse | output | 1 | Single-cycle convert command to the converter |
| conv_mon | output | 1 | Monitor copy of the internal timer pulse when it is selected |
| ext_drv_en | output | 1 | External pin may drive the convert node |
| int_drv_en | output | 1 | Internal timer may drive the convert node |
| seq_active | output | 1 | Acquisition sequence armed |
| sample_cnt_en | output | 1 | Sample counter enable |
| intv_cnt_en | output | 1 | Sample-interval counter enable |
| strobe_n | output | 1 | Active-low strobe output |
| width_viol | output | 1 | Sticky flag: external convert pulse too narrow |
| holdoff_viol | output | 1 | Sticky flag: external convert fell too early |

## Verification
The bench builds the block with MIN_WIDTH_CYC=3, HOLDOFF_CYC=8 and STROBE_CYC=6 instead of the nanosecond-scale defaults. With these values the cases on each side of every threshold fit in a few dozen cycles: pulses of two and three cycles, high times of seven and eight cycles, and a retrigger in the middle of a strobe. The short run also covers both sources, both gates and a full cycle of arming and disarming the sequence.

// File: rtl/acq_conv_pkg.sv
package acq_conv_pkg;
  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_INT = 1'b1
  } conv_src_e;

  // flag vector layout matches viol_clr: bit 0 width, bit 1 holdoff
  typedef struct packed {
    logic holdoff;
    logic width;
  } viol_t;
endpackage

// File: rtl/acq_sync.sv
module acq_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_next
      assign stg_d = stg[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= RST_VAL;
      else        stg[g] <= stg_d;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/acq_conv_check.sv
module acq_conv_check #(
  parameter int MIN_W = 5,
  parameter int HOLD  = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lvl,
  output logic accept,
  output logic width_err,
  output logic holdoff_err
);
  localparam int HW = $clog2(HOLD + 1);
  localparam int LW = $clog2(MIN_W + 1);

  logic          lvl_q, lvl_d;
  logic [HW-1:0] hi_cnt, hi_d;
  logic [LW-1:0] lo_cnt, lo_d;
  logic          pend, pend_d;
  logic          fall, hold_ok, pend_now;

  always_comb begin
    fall        = lvl_q & ~lvl;
    hold_ok     = (hi_cnt >= HW'(HOLD));
    pend_now    = pend | (fall & hold_ok);
    holdoff_err = en & fall & ~hold_ok;
    accept      = en & pend_now & ~lvl & (lo_cnt == LW'(MIN_W - 1));
    width_err   = en & pend & lvl;

    lvl_d  = lvl;
    hi_d   = '0;
    lo_d   = '0;
    pend_d = 1'b0;
    if (en) begin
      if (lvl) hi_d = (hi_cnt == HW'(HOLD)) ? hi_cnt : hi_cnt + 1'b1;
      else     lo_d = (lo_cnt == LW'(MIN_W)) ? lo_cnt : lo_cnt + 1'b1;
      pend_d = pend_now & ~accept & ~lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b1;
      hi_cnt <= '0;
      lo_cnt <= '0;
      pend   <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      hi_cnt <= hi_d;
      lo_cnt <= lo_d;
      pend   <= pend_d;
    end
  end
endmodule

// File: rtl/acq_strobe.sv
module acq_strobe #(
  parameter int LOW_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic strobe_n
);
  localparam int CW = $clog2(LOW_CYC + 1);

  logic [CW-1:0] cnt, cnt_d;
  logic          strobe_d;

  always_comb begin
    strobe_d = strobe_n;
    cnt_d    = cnt;
    if (strobe_n) begin
      if (req) begin
        strobe_d = 1'b0;
        cnt_d    = '0;
      end
    end else if (cnt == CW'(LOW_CYC - 1)) begin
      strobe_d = 1'b1;
    end else begin
      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_n <= 1'b1;
      cnt      <= '0;
    end else begin
      strobe_n <= strobe_d;
      cnt      <= cnt_d;
    end
  end
endmodule

// File: rtl/acq_conv_gate.sv
module acq_conv_gate
  import acq_conv_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_WIDTH_CYC = 5,
  parameter int HOLDOFF_CYC   = 200,
  parameter int STROBE_CYC    = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_conv_n,
  input  logic       ext_trig_n,
  input  logic       ext_gate_n,
  input  logic       sint_pulse,
  input  logic       sw_gate,
  input  logic       src_sel,
  input  logic       seq_done,
  input  logic       sw_clear,
  input  logic       sw_strobe,
  input  logic [1:0] viol_clr,
  output logic       conv_pulse,
  output logic       conv_mon,
  output logic       ext_drv_en,
  output logic       int_drv_en,
  output logic       seq_active,
  output logic       sample_cnt_en,
  output logic       intv_cnt_en,
  output logic       strobe_n,
  output logic       width_viol,
  output logic       holdoff_viol
);
  localparam int NASYNC = 3;

  logic              rst_int_n;
  logic [NASYNC-1:0] async_s;
  logic              conv_s, trig_s, gate_s;
  conv_src_e         src;

  // reset: asserted at once, released through a synchroniser
  acq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  acq_sync #(.WIDTH(NASYNC), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_in_sync (
    .clk(clk), .rst_n(rst_int_n),
    .d({ext_conv_n, ext_trig_n, ext_gate_n}), .q(async_s)
  );
  assign {conv_s, trig_s, gate_s} = async_s;
  assign src = conv_src_e'(src_sel);

  logic ext_accept, ext_width_err, ext_hold_err;
  acq_conv_check #(.MIN_W(MIN_WIDTH_CYC), .HOLD(HOLDOFF_CYC)) u_check (
    .clk(clk), .rst_n(rst_int_n), .en(src == SRC_EXT), .lvl(conv_s),
    .accept(ext_accept), .width_err(ext_width_err), .holdoff_err(ext_hold_err)
  );

  acq_strobe #(.LOW_CYC(STROBE_CYC)) u_strobe (
    .clk(clk), .rst_n(rst_int_n), .req(sw_strobe), .strobe_n(strobe_n)
  );

  // sequencing, gating and flag state
  logic  trig_q, trig_fall, sint_q, int_req, gate_open, req_sel;
  logic  seq_d, conv_d;
  viol_t viol_q, viol_d;

  always_comb begin
    trig_fall = trig_q & ~trig_s;
    int_req   = sint_pulse & ~sint_q;
    gate_open = seq_active & gate_s & ~sw_gate;
    req_sel   = (src == SRC_INT) ? int_req : ext_accept;
    conv_d    = gate_open & req_sel;

    seq_d = seq_active;
    if (seq_done | sw_clear) seq_d = 1'b0;
    else if (trig_fall)      seq_d = 1'b1;

    viol_d.width   = ext_width_err | (viol_q.width   & ~viol_clr[0]);
    viol_d.holdoff = ext_hold_err  | (viol_q.holdoff & ~viol_clr[1]);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      trig_q     <= 1'b1;
      sint_q     <= 1'b0;
      seq_active <= 1'b0;
      conv_pulse <= 1'b0;
      viol_q     <= '0;
    end else begin
      trig_q     <= trig_s;
      sint_q     <= sint_pulse;
      seq_active <= seq_d;
      conv_pulse <= conv_d;
      viol_q     <= viol_d;
    end
  end

  assign sample_cnt_en = seq_active;
  assign intv_cnt_en   = seq_active;
  assign ext_drv_en    = (src == SRC_EXT);
  assign int_drv_en    = (src == SRC_INT);
  assign conv_mon      = (src == SRC_INT) & sint_pulse;
  assign width_viol    = viol_q.width;
  assign holdoff_viol  = viol_q.holdoff;
endmodule

// File: rtl/acq_conv_gate_sva.sv
module acq_conv_gate_sva #(
  parameter int STROBE_CYC = 50
) (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_pulse,
  input logic       seq_active,
  input logic       sw_gate,
  input logic       seq_done,
  input logic       sw_clear,
  input logic       ext_drv_en,
  input logic       int_drv_en,
  input logic       strobe_n,
  input logic       width_viol,
  input logic       holdoff_viol,
  input logic [1:0] viol_clr
);
  localparam int RW = $clog2(STROBE_CYC + 2);

  logic [RW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          low_run <= '0;
    else if (strobe_n)                   low_run <= '0;
    else if (low_run != RW'(STROBE_CYC + 1)) low_run <= low_run + 1'b1;
  end

  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_pulse |=> !conv_pulse);

  assert_needs_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_pulse |-> $past(seq_active));

  assert_sw_gate_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_pulse |-> $past(!sw_gate));

  assert_seq_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done || sw_clear) |=> !seq_active);

  assert_one_driver_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ext_drv_en, int_drv_en}) == 1);

  assert_strobe_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_n) |-> (low_run == RW'(STROBE_CYC)));

  assert_width_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (width_viol && !viol_clr[0]) |=> width_viol);

  assert_holdoff_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (holdoff_viol && !viol_clr[1]) |=> holdoff_viol);
endmodule

bind acq_conv_gate acq_conv_gate_sva #(.STROBE_CYC(STROBE_CYC)) u_sva (
  .clk(clk), .rst_n(rst_n), .conv_pulse(conv_pulse), .seq_active(seq_active),
  .sw_gate(sw_gate), .seq_done(seq_done), .sw_clear(sw_clear),
  .ext_drv_en(ext_drv_en), .int_drv_en(int_drv_en), .strobe_n(strobe_n),
  .width_viol(width_viol), .holdoff_viol(holdoff_viol), .viol_clr(viol_clr)
);

// File: tb/acq_conv_gate_test.sv
module acq_conv_gate_test;
  localparam int MINW = 3;
  localparam int HOLD = 8;
  localparam int STRB = 6;

  logic clk, rst_n;
  logic ext_conv_n, ext_trig_n, ext_gate_n, sint_pulse, sw_gate, src_sel;
  logic seq_done, sw_clear, sw_strobe;
  logic [1:0] viol_clr;
  logic conv_pulse, conv_mon, ext_drv_en, int_drv_en, seq_active;
  logic sample_cnt_en, intv_cnt_en, strobe_n, width_viol, holdoff_viol;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  bit done = 0;

  acq_conv_gate #(.SYNC_STAGES(2), .MIN_WIDTH_CYC(MINW), .HOLDOFF_CYC(HOLD),
                  .STROBE_CYC(STRB)) uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // monitor: every convert pulse must match a queued expectation
  always @(negedge clk) begin
    if (rst_n && conv_pulse) begin
      if (exp_q.size() == 0) chk(0, "R3/R6/R7/R8 unexpected conv_pulse", 1, 0);
      else begin
        int tag;
        tag = exp_q.pop_front();
        chk(tag == int'(src_sel), "R8 conv_pulse source", int'(src_sel), tag);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic phase_end(input string req);
    idle(4);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic ext_pulse(input int lc, input int tail);
    ext_conv_n = 1'b0;
    idle(lc);
    ext_conv_n = 1'b1;
    idle(tail);
  endtask

  task automatic sint_hit(input int n);
    sint_pulse = 1'b1;
    #1 chk(conv_mon == src_sel, "R9 conv_mon mirror", conv_mon, src_sel);
    idle(n);
    sint_pulse = 1'b0;
    idle(5);
  endtask

  task automatic pulse_in(ref logic s);
    s = 1'b1;
    idle(1);
    s = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    ext_conv_n = 1; ext_trig_n = 1; ext_gate_n = 1; sint_pulse = 0;
    sw_gate = 0; src_sel = 0; seq_done = 0; sw_clear = 0; sw_strobe = 0;
    viol_clr = 0; rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(4);
    chk(!seq_active && !sample_cnt_en && !intv_cnt_en, "reset seq", seq_active, 0);
    chk(!conv_pulse && strobe_n && !width_viol && !holdoff_viol, "reset outputs",
        {conv_pulse, strobe_n, width_viol, holdoff_viol}, 4'b0100);

    // R6: no forwarding before the sequence is armed
    idle(20);
    ext_pulse(5, 20);
    phase_end("R6 pulse before arm");

    // R1: trigger arms
    ext_trig_n = 0; idle(3); ext_trig_n = 1; idle(5);
    chk(seq_active && sample_cnt_en && intv_cnt_en, "R1 arm",
        {seq_active, sample_cnt_en, intv_cnt_en}, 3'b111);

    // R3: exact minimum width accepted
    exp_q.push_back(0);
    ext_pulse(MINW, 20);
    phase_end("R3 min-width pulse missing");

    // R4: one cycle short
    ext_pulse(MINW - 1, 20);
    phase_end("R4 short pulse");
    chk(width_viol == 1, "R4 width flag", width_viol, 1);
    chk(holdoff_viol == 0, "R4 no holdoff flag", holdoff_viol, 0);
    idle(5);
    chk(width_viol == 1, "R11 width sticky", width_viol, 1);
    viol_clr = 2'b01; idle(1); viol_clr = 0; idle(1);
    chk(width_viol == 0, "R11 width clear", width_viol, 0);

    // R4: long pulse has no upper limit
    exp_q.push_back(0);
    ext_pulse(40, 20);
    phase_end("R4 long pulse missing");

    // R5: high time exactly HOLD accepted
    exp_q.push_back(0);
    ext_pulse(5, HOLD);
    exp_q.push_back(0);
    ext_pulse(5, 20);
    phase_end("R5 boundary holdoff");
    chk(holdoff_viol == 0, "R5 boundary no flag", holdoff_viol, 0);

    // R5: one cycle early
    exp_q.push_back(0);
    ext_pulse(5, HOLD - 1);
    ext_pulse(5, 20);
    phase_end("R5 early pulse");
    chk(holdoff_viol == 1, "R5 holdoff flag", holdoff_viol, 1);
    chk(width_viol == 0, "R5 no width flag", width_viol, 0);
    viol_clr = 2'b01; idle(1); viol_clr = 0; idle(1);
    chk(holdoff_viol == 1, "R11 wrong clear bit", holdoff_viol, 1);
    viol_clr = 2'b10; idle(1); viol_clr = 0; idle(1);
    chk(holdoff_viol == 0, "R11 holdoff clear", holdoff_viol, 0);

    // R7: hardware and software gates
    ext_gate_n = 0; idle(4);
    ext_pulse(5, 20);
    phase_end("R7 ext gate");
    ext_gate_n = 1; sw_gate = 1; idle(4);
    ext_pulse(5, 20);
    phase_end("R7 sw gate");
    sw_gate = 0; idle(4);

    // R8/R9/R12: internal source
    src_sel = 1; idle(4);
    chk(!ext_drv_en && int_drv_en, "R8 drive enables", {ext_drv_en, int_drv_en}, 2'b01);
    ext_pulse(1, 20);
    phase_end("R8 ext ignored when internal");
    chk(!width_viol && !holdoff_viol, "R8 no flags when internal",
        {width_viol, holdoff_viol}, 0);
    exp_q.push_back(1);
    sint_hit(1);
    exp_q.push_back(1);
    sint_hit(3);
    phase_end("R12 one pulse per rising edge");
    sw_gate = 1;
    sint_hit(1);
    phase_end("R7 sw gate internal");
    sw_gate = 0;

    // R2/R6: end of sequence
    pulse_in(seq_done); idle(2);
    chk(!seq_active && !sample_cnt_en && !intv_cnt_en, "R2 seq_done",
        {seq_active, sample_cnt_en, intv_cnt_en}, 0);
    sint_hit(1);
    phase_end("R6 internal after done");
    src_sel = 0; idle(2);
    chk(ext_drv_en && !int_drv_en, "R8 drive enables ext", {ext_drv_en, int_drv_en}, 2'b10);
    sint_hit(1);
    idle(20);
    ext_pulse(5, 20);
    phase_end("R6 external after done");

    ext_trig_n = 0; idle(3); ext_trig_n = 1; idle(5);
    chk(seq_active == 1, "R1 rearm", seq_active, 1);
    pulse_in(sw_clear); idle(2);
    chk(seq_active == 0, "R2 sw_clear", seq_active, 0);

    // R10: strobe width and retrigger ignored
    begin
      int cnt;
      cnt = 0;
      sw_strobe = 1; idle(1); sw_strobe = 0;
      while (strobe_n == 0 && cnt < 100) begin
        cnt++;
        sw_strobe = (cnt == 2);
        idle(1);
      end
      sw_strobe = 0;
      chk(cnt == STRB, "R10 strobe low width", cnt, STRB);
      idle(3);
      chk(strobe_n == 1, "R10 retrigger ignored", strobe_n, 1);
    end

    report();
  end
endmodule